// File: doc/BRIEF.md
# CDC Source-Data Hold Monitor

This block is a synthesizable watchdog for a data word that crosses from a source clock domain into a destination clock domain. The destination side needs the word to stay still for three destination clock edges after each change, and the edges may be of either polarity. The monitor looks for changes on the source clock by comparing the word with the value it held at the previous rising source edge. Because the changes are judged in the source domain, a fast source cannot hide a change from a slow destination.

Destination edges are turned into level flips by two toggle flops in the destination domain. One flop runs on the rising edge and one on the falling edge. Each flip passes through a synchronizer into the source domain and becomes a one-cycle edge pulse there. The pulses feed a saturating window count. The monitor is conservative: an edge is credited to the current window only after it has crossed, and any edge still inside the synchronizer when a change is seen is thrown away. So the window can close late, but it never closes early. The block gives three outputs in the source domain: a one-cycle violation pulse, a sticky violation flag, and a window-satisfied level.

Top module: `cdc_hold_monitor`

## Requirements
- R1: A change is a difference, at a rising source edge, between `src_data` and the value it had at the previous rising source edge. The first change after reset opens a window and never raises a violation.
- R2: While reset is active and after it is released, all three outputs are 0. The value of `src_data` at reset release becomes the baseline, so a steady nonzero input never counts as a change.
- R3: Each destination edge adds one to the window count, whether it is rising or falling. A rising edge and a falling edge in the same source cycle add two.
- R4: A destination edge that occurs in source cycle k (between rising source edges k and k+1) is credited at rising source edge k+3. Edges that occur before the source cycle in which the change is detected are never credited to that window.
- R5: `window_done` is 1 while a window is open and its count has reached three. It drops to 0 in the cycle after the rising source edge that detects the next change.
- R6: A change detected while a window is open with a count below three raises `viol_pulse` for the one source cycle after the detecting edge. Two violating changes on consecutive edges give two consecutive pulse cycles.
- R7: A violating change also opens a fresh window at count zero, so checking goes on for later data.
- R8: `viol_sticky` is set in the same cycle as the first `viol_pulse` and stays at 1 until reset.
- R9: The count saturates at three. Extra destination edges keep `window_done` high and have no other effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| src_clk | input | 1 | Source domain clock; every output is registered on it |
| dst_clk | input | 1 | Destination domain clock; both of its edges are counted |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously in each domain |
| src_data | input | DATA_W | Source-side data word under watch |
| viol_sticky | output | 1 | Latched violation flag, cleared only by reset |
| viol_pulse | output | 1 | One source cycle high for each violating change |
| window_done | output | 1 | Current window has seen three destination edges |

## Verification
Two functions can fall on the same rising source edge. One is the detection of a change, which both judges the old window and opens a new one. The other is the arrival of a synchronized destination edge, which would add to the count. The sweep makes this happen by toggling the destination clock in the same source cycle that it drives a new data value, and by driving changes on consecutive cycles. The bench computes the credit for each cycle arithmetically from the three-cycle latency and from the rule that older edges are discarded. It then compares `window_done`, `viol_pulse` and `viol_sticky` in every cycle. An edge credited too early, or an edge that leaks across a window restart, shows up as a wrong `window_done` or a missing pulse.

// File: rtl/cdc_hold_pkg.sv
package cdc_hold_pkg;

  // Index of each destination edge polarity in the toggle / pulse vectors.
  typedef enum int {
    EDGE_RISE = 0,
    EDGE_FALL = 1
  } edge_pol_e;

  localparam int unsigned NUM_POL = 2;

  // Bits needed to hold the values 0..maxval.
  function automatic int unsigned width_for(input int unsigned maxval);
    return (maxval < 2) ? 1 : $clog2(maxval + 1);
  endfunction

endpackage

// File: rtl/chm_rst_sync.sv
module chm_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);

  logic [STAGES-1:0] shift_q;
  logic [STAGES-1:0] shift_d;

  always_comb begin
    shift_d = {shift_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n_in) begin
    if (!rst_n_in) begin
      shift_q <= '0;
    end else begin
      shift_q <= shift_d;
    end
  end

  assign rst_n_out = shift_q[STAGES-1];

endmodule

// File: rtl/chm_dst_toggles.sv
module chm_dst_toggles
  import cdc_hold_pkg::*;
(
  input  logic               dst_clk,
  input  logic               dst_rst_n,
  output logic [NUM_POL-1:0] tog_o
);

  logic rise_q, rise_d;
  logic fall_q, fall_d;

  always_comb begin
    rise_d = ~rise_q;
    fall_d = ~fall_q;
  end

  // Flips on every rising destination edge.
  always_ff @(posedge dst_clk or negedge dst_rst_n) begin
    if (!dst_rst_n) begin
      rise_q <= 1'b0;
    end else begin
      rise_q <= rise_d;
    end
  end

  // Flips on every falling destination edge.
  always_ff @(negedge dst_clk or negedge dst_rst_n) begin
    if (!dst_rst_n) begin
      fall_q <= 1'b0;
    end else begin
      fall_q <= fall_d;
    end
  end

  assign tog_o[EDGE_RISE] = rise_q;
  assign tog_o[EDGE_FALL] = fall_q;

endmodule

// File: rtl/chm_toggle_sync.sv
module chm_toggle_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tog_i,
  output logic edge_o
);

  // chain_q[STAGES-1:0] are the synchronizer flops;
  // chain_q[STAGES] holds the previous synchronized level.
  logic [STAGES:0] chain_q;
  logic [STAGES:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-1:0], tog_i};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
    end else begin
      chain_q <= chain_d;
    end
  end

  assign edge_o = chain_q[STAGES] ^ chain_q[STAGES-1];

endmodule

// File: rtl/chm_hold_window.sv
module chm_hold_window
  import cdc_hold_pkg::*;
#(
  parameter int unsigned DATA_W       = 8,
  parameter int unsigned REQ_EDGES    = 3,
  parameter int unsigned BLANK_CYCLES = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [DATA_W-1:0]  data_i,
  input  logic [NUM_POL-1:0] edge_i,
  output logic               viol_pulse_o,
  output logic               viol_sticky_o,
  output logic               window_done_o
);

  localparam int unsigned CNT_W = width_for(REQ_EDGES);
  localparam int unsigned SUM_W = CNT_W + 1;
  localparam int unsigned BLK_W = width_for(BLANK_CYCLES);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(REQ_EDGES);
  localparam logic [SUM_W-1:0] SUM_MAX = SUM_W'(REQ_EDGES);
  localparam logic [BLK_W-1:0] BLK_LOAD = BLK_W'(BLANK_CYCLES);

  logic [DATA_W-1:0] prev_q, prev_d;
  logic              primed_q, primed_d;
  logic              armed_q, armed_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [BLK_W-1:0]  blank_q, blank_d;
  logic              pulse_q, pulse_d;
  logic              sticky_q, sticky_d;

  logic              chg;
  logic              viol_now;
  logic              credit_en;
  logic [SUM_W-1:0]  add_v;
  logic [SUM_W-1:0]  sum_v;
  logic              prev_en, cnt_en, blank_en;

  // Next-state logic
  always_comb begin
    chg       = primed_q && (data_i != prev_q);
    viol_now  = chg && armed_q && (cnt_q < CNT_MAX);
    credit_en = armed_q && (blank_q == '0);

    add_v = '0;
    for (int i = 0; i < int'(NUM_POL); i++) begin
      add_v = add_v + SUM_W'(edge_i[i]);
    end
    sum_v = SUM_W'(cnt_q) + add_v;

    primed_d = 1'b1;
    prev_en  = 1'b1;
    prev_d   = data_i;

    armed_d  = armed_q | chg;

    cnt_en = chg || credit_en;
    if (chg) begin
      cnt_d = '0;
    end else if (sum_v >= SUM_MAX) begin
      cnt_d = CNT_MAX;
    end else begin
      cnt_d = sum_v[CNT_W-1:0];
    end

    blank_en = chg || (blank_q != '0);
    if (chg) begin
      blank_d = BLK_LOAD;
    end else begin
      blank_d = blank_q - BLK_W'(1);
    end

    pulse_d  = viol_now;
    sticky_d = sticky_q | viol_now;
  end

  // Registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q   <= '0;
      primed_q <= 1'b0;
      armed_q  <= 1'b0;
      cnt_q    <= '0;
      blank_q  <= '0;
      pulse_q  <= 1'b0;
      sticky_q <= 1'b0;
    end else begin
      if (prev_en)  prev_q  <= prev_d;
      if (cnt_en)   cnt_q   <= cnt_d;
      if (blank_en) blank_q <= blank_d;
      primed_q <= primed_d;
      armed_q  <= armed_d;
      pulse_q  <= pulse_d;
      sticky_q <= sticky_d;
    end
  end

  assign viol_pulse_o  = pulse_q;
  assign viol_sticky_o = sticky_q;
  assign window_done_o = armed_q && (cnt_q == CNT_MAX);

  // R1: a change with no open window never produces a violation
  p_unarmed_no_viol_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (chg && !armed_q) |=> !viol_pulse_o);

  // R3: without a change the count never goes down
  p_cnt_monotone_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !chg |=> (cnt_q >= $past(cnt_q)));

  // R4: while edges in flight are being discarded, the count does not move
  p_blank_holds_cnt_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!chg && blank_q != '0) |=> $stable(cnt_q));

  // R5: a detected change always clears the satisfied indication
  p_change_clears_done_r5: assert property (@(posedge clk) disable iff (!rst_n)
    chg |=> !window_done_o);

  // R7: a violating change restarts the window from zero
  p_viol_restart_r7: assert property (@(posedge clk) disable iff (!rst_n)
    viol_now |=> (cnt_q == '0 && armed_q));

  // R8: the sticky flag never clears and accompanies every pulse
  p_sticky_holds_r8: assert property (@(posedge clk) disable iff (!rst_n)
    viol_sticky_o |=> viol_sticky_o);
  p_pulse_sets_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    viol_pulse_o |-> viol_sticky_o);

  // R9: once satisfied, the window stays satisfied until a change
  p_done_stays_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (window_done_o && !chg) |=> window_done_o);

endmodule

// File: rtl/cdc_hold_monitor.sv
module cdc_hold_monitor
  import cdc_hold_pkg::*;
#(
  parameter int unsigned DATA_W      = 8,
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned REQ_EDGES   = 3,
  parameter int unsigned RST_STAGES  = 2
) (
  input  logic              src_clk,
  input  logic              dst_clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] src_data,
  output logic              viol_sticky,
  output logic              viol_pulse,
  output logic              window_done
);

  logic               src_rst_n;
  logic               dst_rst_n;
  logic [NUM_POL-1:0] dst_tog;
  logic [NUM_POL-1:0] src_edge;

  chm_rst_sync #(.STAGES(RST_STAGES)) u_src_rst (
    .clk       (src_clk),
    .rst_n_in  (rst_n),
    .rst_n_out (src_rst_n)
  );

  chm_rst_sync #(.STAGES(RST_STAGES)) u_dst_rst (
    .clk       (dst_clk),
    .rst_n_in  (rst_n),
    .rst_n_out (dst_rst_n)
  );

  chm_dst_toggles u_toggles (
    .dst_clk   (dst_clk),
    .dst_rst_n (dst_rst_n),
    .tog_o     (dst_tog)
  );

  for (genvar g = 0; g < int'(NUM_POL); g++) begin : g_pol
    chm_toggle_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk    (src_clk),
      .rst_n  (src_rst_n),
      .tog_i  (dst_tog[g]),
      .edge_o (src_edge[g])
    );
  end

  chm_hold_window #(
    .DATA_W       (DATA_W),
    .REQ_EDGES    (REQ_EDGES),
    .BLANK_CYCLES (SYNC_STAGES)
  ) u_window (
    .clk           (src_clk),
    .rst_n         (src_rst_n),
    .data_i        (src_data),
    .edge_i        (src_edge),
    .viol_pulse_o  (viol_pulse),
    .viol_sticky_o (viol_sticky),
    .window_done_o (window_done)
  );

endmodule

// File: tb/cdc_hold_monitor_tb_top.sv
module cdc_hold_monitor_tb_top;

  localparam int DW = 8;

  logic          src_clk = 1'b0;
  logic          dst_clk = 1'b0;
  logic          rst_n   = 1'b0;
  logic [DW-1:0] src_data = 8'hA5;
  logic          viol_sticky, viol_pulse, window_done;

  int n_tests = 0;
  int n_fail  = 0;
  bit finished = 1'b0;

  // Bench model state
  int  tog_h [0:4095];
  int  t_idx = 0;
  bit  m_armed = 1'b0;
  int  m_open = 0;
  bit  chg_pend = 1'b0;
  bit  exp_sticky = 1'b0;
  bit  restart_case = 1'b0;
  string done_tag = "R5";

  always #5 src_clk = ~src_clk;

  cdc_hold_monitor #(.DATA_W(DW)) dut_i (
    .src_clk     (src_clk),
    .dst_clk     (dst_clk),
    .rst_n       (rst_n),
    .src_data    (src_data),
    .viol_sticky (viol_sticky),
    .viol_pulse  (viol_pulse),
    .window_done (window_done)
  );

  task automatic chk(input string tag, input string what, input logic act, input logic exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s at cycle %0d: actual=%b expected=%b", tag, what, t_idx, act, exp);
    end
  endtask

  // Credit of the window at the register state after rising edge t:
  // edges from cycles open..t-3 count, saturating at three.
  function automatic int credit_at(input int t);
    int s = 0;
    if (!m_armed) return 0;
    for (int m = m_open; m <= t - 3; m++) s += tog_h[m];
    return (s > 3) ? 3 : s;
  endfunction

  // One source cycle: drive a change and/or up to two destination edges.
  task automatic cyc(input bit chg, input int ntog, input bit check);
    bit    exp_pulse;
    bit    exp_done;
    string ptag;
    @(posedge src_clk);
    t_idx++;
    exp_pulse = 1'b0;
    ptag = "R6";
    if (chg_pend) begin
      if (!m_armed) ptag = "R1";
      exp_pulse = m_armed && (credit_at(t_idx - 1) < 3);
      restart_case = exp_pulse;
      m_open = t_idx;
      m_armed = 1'b1;
    end
    exp_sticky = exp_sticky | exp_pulse;
    exp_done = m_armed && (credit_at(t_idx) >= 3);
    #3;
    if (chg) src_data = src_data + 8'd1;
    chg_pend = chg;
    #2;
    if (ntog >= 1) begin dst_clk = ~dst_clk; tog_h[t_idx]++; end
    #2;
    if (ntog >= 2) begin dst_clk = ~dst_clk; tog_h[t_idx]++; end
    #2;
    if (check) begin
      chk(ptag, "viol_pulse", viol_pulse, exp_pulse);
      chk("R8", "viol_sticky", viol_sticky, exp_sticky);
      chk(restart_case ? "R7" : done_tag, "window_done", window_done, exp_done);
    end
  endtask

  initial begin
    #(20000 * 10);
    if (!finished) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 4096; i++) tog_h[i] = 0;
    // Reset phase with destination activity
    for (int i = 0; i < 4; i++) cyc(1'b0, 2, 1'b0);
    chk("R2", "viol_pulse in reset", viol_pulse, 1'b0);
    chk("R2", "window_done in reset", window_done, 1'b0);
    chk("R2", "viol_sticky in reset", viol_sticky, 1'b0);
    @(posedge src_clk);
    #3 rst_n = 1'b1;
    for (int i = 0; i < 6; i++) cyc(1'b0, 2, 1'b0);
    for (int i = 0; i < 6; i++) cyc(1'b0, 0, 1'b0);
    // Steady nonzero data after reset: nothing must be reported (R2)
    for (int i = 0; i < 4; i++) begin
      cyc(1'b0, 1, 1'b0);
      chk("R2", "viol_pulse steady", viol_pulse, 1'b0);
      chk("R2", "window_done steady", window_done, 1'b0);
      chk("R2", "viol_sticky steady", viol_sticky, 1'b0);
    end
    for (int i = 0; i < 4; i++) cyc(1'b0, 0, 1'b0);

    // Model phase
    t_idx = 0;
    for (int i = 0; i < 4096; i++) tog_h[i] = 0;
    m_armed = 1'b0;
    chg_pend = 1'b0;

    for (int f = 0; f < 2; f++) begin
      for (int p = 1; p <= 2; p++) begin
        for (int n = 0; n <= 5; n++) begin
          for (int d = 0; d <= 2; d++) begin
            int rem;
            done_tag = (f == 1) ? "R4" : (n > 3) ? "R9" : (p == 2) ? "R3" : "R5";
            cyc(1'b1, f, 1'b1);
            rem = n;
            while (rem > 0) begin
              int k;
              k = (rem < p) ? rem : p;
              cyc(1'b0, k, 1'b1);
              rem -= k;
            end
            for (int w = 0; w < d; w++) cyc(1'b0, 0, 1'b1);
          end
        end
      end
    end
    // Long hold to let the final window complete
    done_tag = "R5";
    for (int i = 0; i < 3; i++) cyc(1'b0, 1, 1'b1);
    for (int i = 0; i < 5; i++) cyc(1'b0, 0, 1'b1);

    // Sticky clears only through reset (R8)
    chk("R8", "viol_sticky before reset", viol_sticky, 1'b1);
    @(posedge src_clk);
    #3 rst_n = 1'b0;
    #2;
    chk("R8", "viol_sticky after reset", viol_sticky, 1'b0);
    chk("R2", "viol_pulse after reset", viol_pulse, 1'b0);
    chk("R2", "window_done after reset", window_done, 1'b0);

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule